// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds the alarm setting of a real-time clock: eight byte-wide time-unit slots that store two BCD digits each. The slots, in ascending time order, are milliseconds, hundredths/tenths, seconds, minutes, hours, day-of-week, day-of-month and month. The milliseconds ones digit and the day-of-week tens digit are not stored, which leaves 56 bits. Software reads and writes the slots over a simple byte bus. When no alarm is wanted, the slots serve as plain scratch storage.

Every cycle the stored digits are compared with the live BCD time presented by the counter chain. A stored digit of 0xC or above, meaning its two upper bits are both 1, is a wildcard that matches any live value. The block raises a one-cycle alarm event on the cycle in which the comparison turns true. A separately enabled, active-low standby alarm latches on that event. It stays asserted until software withdraws the enable or wipes the alarm storage.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset all alarm slots read 0x00, the standby enable reads 0, and `stbyAlarmN` is 1.
- R2: Alarm slot k (k = 0..7) is written and read at bus address 0x08+k. In slot 0 the low nibble, and in slot 5 the high nibble, always read 0, and any write to them is dropped.
- R3: `alarmEvt` is 1 for exactly one cycle when the comparison turns from false to true. It is 0 while a match persists. The live time uses the same layout as the slots: slot k is at `liveTime[8k+7:8k]`, with the ones digit in the low nibble.
- R4: A stored digit whose bits [3:2] are both 1 matches any live digit.
- R5: The live milliseconds ones digit (`liveTime[3:0]`) and the live day-of-week tens digit (`liveTime[47:44]`) never affect the comparison.
- R6: Writing 0xFF to address 0x13 sets every alarm slot to 0x00. Any other value written there changes nothing.
- R7: Bit 0 of address 0x16 is the standby enable. It is readable, and the other seven bits read 0.
- R8: If an alarm event occurs while the enable is 1, `stbyAlarmN` goes to 0 on the next cycle and stays there. An event that occurs while the enable is 0 leaves it at 1.
- R9: Writing a value with bit 0 = 0 to address 0x16, or issuing the clear of R6, returns `stbyAlarmN` to 1 on the next cycle.
- R10: Reads from addresses outside 0x08..0x0F and 0x16 return 0x00. Writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 5 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| liveTime | input | 64 | Current BCD time from the counter chain |
| alarmEvt | output | 1 | One-cycle pulse when the alarm matches |
| stbyAlarmN | output | 1 | Latched standby alarm, active low |

## Verification
A corrupted slot nibble shows up at once on the bus read of that slot. It also moves or suppresses the next `alarmEvt`, which appears in the same cycle the live time changes. A stale match register shows as a missing or repeated event one cycle after a match begins. A wrong standby latch shows on `stbyAlarmN` in the cycle after an event, an enable write or a clear. The bench therefore compares all three outputs in every cycle, with live time drawn mostly from the stored setting so that matches are frequent.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  parameter int UNITS = 8;
  parameter int MS_UNIT = 0;   // low digit not stored
  parameter int DOW_UNIT = 5;  // high digit not stored
  localparam int IDX_W = $clog2(UNITS);
  localparam int TIME_W = UNITS * 8;

  typedef struct packed {
    logic wrAlarm;
    logic [IDX_W-1:0] idx;
    logic clrAll;
    logic [7:0] data;
  } strobe_t;

  function automatic bit digitUsed(int unit, int hi);
    return !((unit == MS_UNIT && hi == 0) || (unit == DOW_UNIT && hi == 1));
  endfunction
endpackage

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t stb,
  input  logic [TIME_W-1:0] liveTime,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0] rdByte,
  output logic alarmEvt
);
  logic [TIME_W-1:0] storeFlat;
  logic [UNITS*2-1:0] digOk;
  logic matchNow;
  logic matchQ;

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    for (genvar d = 0; d < 2; d++) begin : g_dig
      if (digitUsed(k, d)) begin : g_on
        logic [3:0] nibQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) nibQ <= '0;
          else if (stb.clrAll) nibQ <= '0;
          else if (stb.wrAlarm && stb.idx == IDX_W'(k)) nibQ <= stb.data[d*4 +: 4];
        end
        assign storeFlat[k*8 + d*4 +: 4] = nibQ;
        assign digOk[k*2 + d] = (nibQ[3:2] == 2'b11) || (nibQ == liveTime[k*8 + d*4 +: 4]);
      end else begin : g_off
        assign storeFlat[k*8 + d*4 +: 4] = 4'h0;
        assign digOk[k*2 + d] = 1'b1;
      end
    end
  end

  assign matchNow = &digOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else matchQ <= matchNow;
  end

  assign alarmEvt = matchNow & ~matchQ;
  assign rdByte = storeFlat[rdIdx*8 +: 8];

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> !alarmEvt);
  a_r3_held_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && $past(matchNow)) |-> !alarmEvt);
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (storeFlat == '0));
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrAlarm && !stb.clrAll && stb.idx == IDX_W'(2)) |=> (storeFlat[23:16] == $past(stb.data)));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ALARM_BASE = 8,
  parameter int CLEAR_ADDR = 'h13,
  parameter int STBY_ADDR = 'h16
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic [7:0] rdByte,
  input  logic alarmEvt,
  output strobe_t stb,
  output logic [IDX_W-1:0] rdIdx,
  output logic [7:0] busRdData,
  output logic stbyAlarmN
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ALARM_BASE);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLEAR_ADDR);
  localparam logic [ADDR_W-1:0] STBY_A = ADDR_W'(STBY_ADDR);

  logic hitAlarm, hitStby, stbyWr, stbyRelease;
  logic stbyEn, stbyLatch;
  logic [ADDR_W-1:0] offs;

  assign offs = busAddr - BASE_A;
  assign hitAlarm = (int'(busAddr) >= ALARM_BASE) && (int'(busAddr) < ALARM_BASE + UNITS);
  assign hitStby = (busAddr == STBY_A);
  assign rdIdx = offs[IDX_W-1:0];

  always_comb begin
    stb.wrAlarm = busWr && hitAlarm;
    stb.idx = offs[IDX_W-1:0];
    stb.clrAll = busWr && (busAddr == CLR_A) && (busWrData == 8'hFF);
    stb.data = busWrData;
  end

  assign stbyWr = busWr && hitStby;
  assign stbyRelease = stb.clrAll || (stbyWr && !busWrData[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyEn <= 1'b0;
      stbyLatch <= 1'b0;
    end else begin
      if (stbyWr) stbyEn <= busWrData[0];
      if (stbyRelease) stbyLatch <= 1'b0;
      else if (alarmEvt && stbyEn) stbyLatch <= 1'b1;
    end
  end

  assign stbyAlarmN = ~stbyLatch;

  always_comb begin
    if (hitAlarm) busRdData = rdByte;
    else if (hitStby) busRdData = {7'b0, stbyEn};
    else busRdData = 8'h00;
  end

  a_r8_fires: assert property (@(posedge clk) disable iff (!rstN)
    (alarmEvt && stbyEn && !stbyRelease) |=> !stbyAlarmN);
  a_r8_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stbyAlarmN && !stbyRelease) |=> !stbyAlarmN);
  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stbyAlarmN) |-> $past(stbyEn));
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    stbyRelease |=> stbyAlarmN);
  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    stbyWr |=> (stbyEn == $past(busWrData[0])));
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ALARM_BASE = 8,
  parameter int CLEAR_ADDR = 'h13,
  parameter int STBY_ADDR = 'h16
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [TIME_W-1:0] liveTime,
  output logic alarmEvt,
  output logic stbyAlarmN
);
  strobe_t stb;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0] rdByte;

  alarm_ctrl #(
    .ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE),
    .CLEAR_ADDR(CLEAR_ADDR), .STBY_ADDR(STBY_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .rdByte(rdByte), .alarmEvt(alarmEvt),
    .stb(stb), .rdIdx(rdIdx), .busRdData(busRdData), .stbyAlarmN(stbyAlarmN)
  );

  alarm_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .liveTime(liveTime),
    .rdIdx(rdIdx), .rdByte(rdByte), .alarmEvt(alarmEvt)
  );
endmodule

// File: tb/alarm_cmp_top_bench.sv
module alarm_cmp_top_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, busWr;
  logic [4:0] busAddr;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic [63:0] liveTime;
  logic alarmEvt, stbyAlarmN;

  alarm_cmp_top u_alarm_cmp_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .liveTime(liveTime),
    .alarmEvt(alarmEvt), .stbyAlarmN(stbyAlarmN)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mMem [8];
  bit mEn = 0, mLatch = 0, mMatchQ = 0;

  function automatic bit dUsed(int k, int d);
    return !((k == 0 && d == 0) || (k == 5 && d == 1));
  endfunction

  function automatic logic [7:0] maskByte(int k, logic [7:0] b);
    logic [7:0] r = b;
    if (!dUsed(k, 0)) r[3:0] = 4'h0;
    if (!dUsed(k, 1)) r[7:4] = 4'h0;
    return r;
  endfunction

  function automatic bit mMatch(logic [63:0] lt);
    for (int k = 0; k < 8; k++)
      for (int d = 0; d < 2; d++) begin
        logic [3:0] n = mMem[k][d*4 +: 4];
        if (dUsed(k, d) && n[3:2] != 2'b11 && n != lt[k*8 + d*4 +: 4]) return 1'b0;
      end
    return 1'b1;
  endfunction

  function automatic logic [7:0] mRead(logic [4:0] a);
    if (a >= 5'h08 && a <= 5'h0F) return mMem[a - 5'h08];
    if (a == 5'h16) return {7'b0, mEn};
    return 8'h00;
  endfunction

  function automatic logic [63:0] liveFor();
    logic [63:0] lt;
    for (int k = 0; k < 8; k++)
      for (int d = 0; d < 2; d++) begin
        logic [3:0] n = mMem[k][d*4 +: 4];
        if (!dUsed(k, d) || n[3:2] == 2'b11) lt[k*8 + d*4 +: 4] = 4'($urandom % 16);
        else lt[k*8 + d*4 +: 4] = n;
      end
    return lt;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit wr, logic [4:0] a, logic [7:0] d, logic [63:0] lt, string tag);
    bit m, evt, clr, rel;
    busWr = wr; busAddr = a; busWrData = d; liveTime = lt;
    #2;
    m = mMatch(lt);
    evt = m && !mMatchQ;
    chk(tag, "alarmEvt R3", 8'(alarmEvt), 8'(evt));
    chk(tag, "stbyAlarmN R8", 8'(stbyAlarmN), 8'(!mLatch));
    chk(tag, "busRdData R2", busRdData, mRead(a));
    clr = wr && a == 5'h13 && d == 8'hFF;
    rel = clr || (wr && a == 5'h16 && !d[0]);
    @(posedge clk);
    if (rel) mLatch = 0;
    else if (evt && mEn) mLatch = 1;
    if (clr) for (int k = 0; k < 8; k++) mMem[k] = 8'h00;
    else if (wr && a >= 5'h08 && a <= 5'h0F) mMem[a - 5'h08] = maskByte(int'(a - 5'h08), d);
    if (wr && a == 5'h16) mEn = d[0];
    mMatchQ = m;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  localparam logic [63:0] ONES = 64'h1111_1111_1111_1111;
  localparam logic [63:0] TGT  = 64'h0912_0323_1545_2150;

  initial begin
    void'($urandom(32'h5EED));
    for (int k = 0; k < 8; k++) mMem[k] = 8'h00;
    rstN = 0; busWr = 0; busAddr = 0; busWrData = 0; liveTime = ONES;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    for (int k = 0; k < 8; k++) cyc(0, 5'(8 + k), 8'h00, ONES, "R1");
    cyc(0, 5'h16, 8'h00, ONES, "R1");
    // R2: storage and the two missing nibbles
    cyc(1, 5'h0B, 8'h47, ONES, "R2");
    cyc(0, 5'h0B, 8'h00, ONES, "R2");
    cyc(1, 5'h08, 8'h5A, ONES, "R2");
    cyc(0, 5'h08, 8'h00, ONES, "R2");
    cyc(1, 5'h0D, 8'h93, ONES, "R2");
    cyc(0, 5'h0D, 8'h00, ONES, "R2");
    // R10: unmapped locations
    cyc(1, 5'h02, 8'h55, ONES, "R10");
    cyc(0, 5'h02, 8'h00, ONES, "R10");
    cyc(1, 5'h1F, 8'hFF, ONES, "R10");
    cyc(0, 5'h0B, 8'h00, ONES, "R10");
    // R7: enable register
    cyc(1, 5'h16, 8'hFF, ONES, "R7");
    cyc(0, 5'h16, 8'h00, ONES, "R7");
    // R3: exact match pulses once, then stays quiet
    for (int k = 0; k < 8; k++) cyc(1, 5'(8 + k), TGT[k*8 +: 8], ONES, "R3");
    cyc(0, 5'h0C, 8'h00, TGT, "R3");
    cyc(0, 5'h0C, 8'h00, TGT, "R3");
    cyc(0, 5'h0C, 8'h00, TGT, "R3");
    // R8: standby latched and held
    cyc(0, 5'h16, 8'h00, ONES, "R8");
    cyc(0, 5'h16, 8'h00, ONES, "R8");
    // R9: release via enable write
    cyc(1, 5'h16, 8'h00, ONES, "R9");
    cyc(0, 5'h16, 8'h00, TGT, "R9");
    cyc(0, 5'h16, 8'h00, ONES, "R8");
    cyc(0, 5'h16, 8'h00, TGT, "R8");
    // R5: excluded live digits vary without effect
    cyc(0, 5'h08, 8'h00, TGT ^ 64'h0000_F000_0000_000F, "R5");
    cyc(0, 5'h08, 8'h00, TGT ^ 64'h0000_A000_0000_0005, "R5");
    // R4: wildcard hours
    cyc(1, 5'h0C, 8'hCC, ONES, "R4");
    cyc(1, 5'h16, 8'h01, TGT ^ 64'h0000_0033_0000_0000, "R4");
    cyc(0, 5'h0C, 8'h00, TGT ^ 64'h0000_0055_0000_0000, "R4");
    // R6: non-FF to clear address ignored, FF clears and releases
    cyc(1, 5'h13, 8'hFE, ONES, "R6");
    cyc(0, 5'h0A, 8'h00, ONES, "R6");
    cyc(1, 5'h13, 8'hFF, ONES, "R6");
    cyc(0, 5'h0A, 8'h00, ONES, "R6");
    cyc(0, 5'h0F, 8'h00, ONES, "R9");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      bit wr = 0;
      logic [4:0] a = 5'($urandom % 32);
      logic [7:0] d = 8'($urandom);
      logic [63:0] lt = ($urandom % 4 != 0) ? liveFor() : {$urandom, $urandom};
      if (r < 35) begin
        wr = 1; a = 5'(8 + $urandom % 8);
        if ($urandom % 3 == 0) d[7:4] = 4'hC | 4'($urandom % 4);
        if ($urandom % 3 == 0) d[3:0] = 4'hC | 4'($urandom % 4);
      end else if (r < 38) begin
        wr = 1; a = 5'h13; d = 8'hFF;
      end else if (r < 41) begin
        wr = 1; a = 5'h13;
      end else if (r < 50) begin
        wr = 1; a = 5'h16;
      end else if (r < 55) begin
        wr = 1;
      end
      cyc(wr, a, d, lt, "RND");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule